// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM Core

This block is the storage core of a synchronous static RAM with an 18-bit word split into two 9-bit byte lanes. Each lane holds eight data bits and one parity bit, and the core stores the parity bit like any other bit. A burst address generator outside the block supplies the word address and a strobe that marks an access. On each rising clock edge the core checks three chip enables. It then decodes the cycle as a read, a write or a deselect. A write is applied at once with a per-lane mask. A read is returned through a two-register pipeline, and the block drives a tri-state enable for the data bus.

Two inputs act without waiting for the clock. An output-enable input can silence the bus at any time. A sleep input silences the bus, throws away any read still in the pipeline and keeps the stored words. Once sleep is released, the core ignores accesses for a fixed number of clock cycles. It then accepts commands again.

Top module: `sspb_sram_core`

## Requirements
- R1: A cycle is accepted only when `acc_vld` is 1, `ce1_n` is 0, `ce2` is 1 and `ce3_n` is 0 at the clock edge. With any other combination, the edge writes nothing and issues no read.
- R2: When `gw_n` is 0 in an accepted cycle, both lanes are written whatever `bwe_n` and `bsel_n` are.
- R3: When `gw_n` is 1 and `bwe_n` is 1, an accepted cycle is a read, whatever `bsel_n` is.
- R4: When `gw_n` is 1 and `bwe_n` is 0, `bsel_n[0]`=0 writes lane A (word bits 8:0) and `bsel_n[1]`=0 writes lane B (word bits 17:9). Each lane is 8 data bits with its parity bit as the top bit. With both selects at 1, the cycle is a read and no lane changes.
- R5: A read sampled at edge k presents the word on `rdata`, with `dq_oe` at 1 when `oe_n` is 0, after edge k+1.
- R6: If edge k accepts no read (deselect, idle or write), `dq_oe` is 0 after edge k+1.
- R7: `oe_n` at 1 forces `dq_oe` to 0 at once, with no clock edge needed.
- R8: Write data is stored at the edge that samples the write. A read of the same address sampled at the next edge returns the new word.
- R9: While `sleep` is 1, `dq_oe` is 0 at once and no cycle is accepted. A read sampled before `sleep` rose never reaches the output. Stored words are kept.
- R10: After `sleep` falls, the first `WAKE_CYC` rising edges (default 4) accept no cycle. The next edge accepts one.
- R11: After a synchronous reset with `rst_n` at 0, `dq_oe` is 0 and no read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| acc_vld | input | 1 | Access strobe from the address generator |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | NBYTE (2) | Per-lane write selects, active low, bit 0 = lane A |
| addr | input | AW (6) | Word address |
| wdata | input | NBYTE*(DBITS+1) (18) | Write word |
| rdata | output | NBYTE*(DBITS+1) (18) | Read word from the output register |
| dq_oe | output | 1 | Tri-state enable for the data bus |

## Verification
On every cycle, the assertions check several rules. A global write enables every lane. No lane is written during the wake-up interval. A read held in the first stage always reaches the output stage, and a non-read never does. Sleep empties the pipeline. A write never drives the bus two edges later. Other behaviour can be seen only by running scenarios against a reference memory. This covers the stored contents under each byte mask and the reads of words just written. It also covers the effect of rejected chip-enable combinations, the data kept through sleep and the exact edge at which commands are accepted again.

// File: rtl/sspb_pkg.sv
// Shared types for the synchronous SRAM core.
// Assumes: nothing beyond IEEE 1800-2017.
package sspb_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    // True when the three chip enables all select the device.
    function automatic logic chip_sel(input logic c1_n, input logic c2, input logic c3_n);
        return !c1_n && c2 && !c3_n;
    endfunction
endpackage

// File: rtl/sspb_cmd_decode.sv
// Decodes one clock cycle into idle, read or write, with a per-lane write mask.
// Global write outranks byte write. Assumes: hold covers sleep, wake-up and reset.
module sspb_cmd_decode
    import sspb_pkg::*;
#(
    parameter int NBYTE = 2
) (
    input  logic             acc_vld,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [NBYTE-1:0] bsel_n,
    input  logic             hold,
    output cmd_e             cmd,
    output logic [NBYTE-1:0] wr_mask
);
    logic             take;
    logic [NBYTE-1:0] lane_sel;

    // Purpose: pick the lanes to write from the write-control priority.
    always_comb begin
        if (!gw_n)      lane_sel = '1;
        else if (bwe_n) lane_sel = '0;
        else            lane_sel = ~bsel_n;
    end

    // Purpose: classify the cycle and gate the mask with acceptance.
    always_comb begin
        take = acc_vld && !hold && chip_sel(ce1_n, ce2, ce3_n);
        if (!take) begin
            cmd     = CMD_IDLE;
            wr_mask = '0;
        end else if (|lane_sel) begin
            cmd     = CMD_WRITE;
            wr_mask = lane_sel;
        end else begin
            cmd     = CMD_READ;
            wr_mask = '0;
        end
    end
endmodule

// File: rtl/sspb_wake_timer.sv
// Counts clock cycles after sleep is released and holds off decodes until done.
// Assumes: sleep may change at any time. The counter reloads while sleep is high.
module sspb_wake_timer #(
    parameter int WAKE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic busy
);
    localparam int CW = $clog2(WAKE_CYC + 1) + 1;

    logic [CW-1:0] cnt;

    // Purpose: reload on sleep, clear on reset, count down to zero otherwise.
    always_ff @(posedge clk or posedge sleep) begin
        if (sleep)           cnt <= CW'(WAKE_CYC);
        else if (!rst_n)     cnt <= '0;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/sspb_lane_array.sv
// Storage split into byte lanes, each written under its own mask bit.
// Read is combinational from rd_addr. Assumes: contents are not reset.
module sspb_lane_array #(
    parameter int LANE_W = 9,
    parameter int NBYTE  = 2,
    parameter int AW     = 6
) (
    input  logic                    clk,
    input  logic [NBYTE-1:0]        wr_mask,
    input  logic [AW-1:0]           wr_addr,
    input  logic [NBYTE*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           rd_addr,
    output logic [NBYTE*LANE_W-1:0] rd_word
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Purpose: store this lane when its mask bit is set.
        always_ff @(posedge clk) begin
            if (wr_mask[g]) mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_word[g*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/sspb_read_pipe.sv
// Two-register read path: a command/address stage, then an output data stage.
// Sleep clears both stages at once. Assumes: rd_word is read from s1_addr.
module sspb_read_pipe #(
    parameter int WORD_W = 18,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              oe_n,
    input  logic              rd_cmd,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] rd_word,
    output logic [AW-1:0]     s1_addr,
    output logic              s1_rd,
    output logic [WORD_W-1:0] rdata,
    output logic              dq_oe
);
    logic s2_vld;

    // Purpose: first stage holds the registered read command and address.
    always_ff @(posedge clk or posedge sleep) begin
        if (sleep)       s1_rd <= 1'b0;
        else if (!rst_n) s1_rd <= 1'b0;
        else             s1_rd <= rd_cmd;
    end

    // Purpose: address register, no reset needed.
    always_ff @(posedge clk) begin
        s1_addr <= addr;
    end

    // Purpose: output stage captures array data for reads.
    always_ff @(posedge clk or posedge sleep) begin
        if (sleep)       s2_vld <= 1'b0;
        else if (!rst_n) s2_vld <= 1'b0;
        else             s2_vld <= s1_rd;
    end

    // Purpose: output data register, loaded only by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (s1_rd) rdata <= rd_word;
    end

    assign dq_oe = s2_vld && !oe_n && !sleep;

    AST_RD_REACHES_OUT: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        s1_rd |=> s2_vld);  // R5
    AST_NONREAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        !s1_rd |=> !s2_vld);  // R6
    AST_SLEEP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (!s2_vld && !s1_rd));  // R9
endmodule

// File: rtl/sspb_sram_core.sv
// Top of the synchronous SRAM core: decode, wake-up hold-off, lane storage, read pipe.
// Assumes: the address comes from an external burst generator, one word per cycle.
module sspb_sram_core
    import sspb_pkg::*;
#(
    parameter int DBITS    = 8,
    parameter int NBYTE    = 2,
    parameter int AW       = 6,
    parameter int WAKE_CYC = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sleep,
    input  logic                          oe_n,
    input  logic                          ce1_n,
    input  logic                          ce2,
    input  logic                          ce3_n,
    input  logic                          acc_vld,
    input  logic                          gw_n,
    input  logic                          bwe_n,
    input  logic [NBYTE-1:0]              bsel_n,
    input  logic [AW-1:0]                 addr,
    input  logic [NBYTE*(DBITS+1)-1:0]    wdata,
    output logic [NBYTE*(DBITS+1)-1:0]    rdata,
    output logic                          dq_oe
);
    localparam int LANE_W = DBITS + 1;
    localparam int WORD_W = NBYTE * LANE_W;

    cmd_e              cmd;
    logic [NBYTE-1:0]  wr_mask;
    logic              wake_busy;
    logic              hold;
    logic [AW-1:0]     s1_addr;
    logic              s1_rd;
    logic [WORD_W-1:0] rd_word;

    assign hold = sleep || wake_busy || !rst_n;

    sspb_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .busy(wake_busy)
    );

    sspb_cmd_decode #(.NBYTE(NBYTE)) u_dec (
        .acc_vld(acc_vld), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .hold(hold),
        .cmd(cmd), .wr_mask(wr_mask)
    );

    sspb_lane_array #(.LANE_W(LANE_W), .NBYTE(NBYTE), .AW(AW)) u_arr (
        .clk(clk), .wr_mask(wr_mask), .wr_addr(addr), .wdata(wdata),
        .rd_addr(s1_addr), .rd_word(rd_word)
    );

    sspb_read_pipe #(.WORD_W(WORD_W), .AW(AW)) u_pipe (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n),
        .rd_cmd(cmd == CMD_READ), .addr(addr), .rd_word(rd_word),
        .s1_addr(s1_addr), .s1_rd(s1_rd), .rdata(rdata), .dq_oe(dq_oe)
    );

    AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_IDLE && !gw_n) |-> (wr_mask == '1));  // R2
    AST_WAKE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_busy |-> (wr_mask == '0 && cmd == CMD_IDLE));  // R10
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_mask) |=> ##1 !dq_oe);  // R6
    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_sel(ce1_n, ce2, ce3_n) |-> (wr_mask == '0));  // R1
endmodule

// File: tb/sspb_sram_core_bench.sv
`timescale 1ns/1ps
module sspb_sram_core_bench;
    localparam int AW = 6;
    localparam int WAKE = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 0, rst_n = 0, sleep = 0, oe_n = 0;
    logic ce1_n = 1, ce2 = 0, ce3_n = 1, acc_vld = 0, gw_n = 1, bwe_n = 1;
    logic [1:0] bsel_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [17:0] wdata = '0;
    logic [17:0] rdata;
    logic dq_oe;

    int total = 0, bad = 0;
    bit done = 0;

    logic [17:0] m_mem [DEPTH];
    logic m_s1 = 0, m_s2 = 0;
    logic [AW-1:0] m_s1_addr = '0;
    logic [17:0] m_dout = '0;
    int m_cnt = 0;

    sspb_sram_core #(.AW(AW), .WAKE_CYC(WAKE)) u_sspb_sram_core (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .acc_vld(acc_vld),
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    // Lanes to write, derived from the write-control rules (R2, R3, R4).
    function automatic logic [1:0] exp_mask(input logic g, input logic b, input logic [1:0] s);
        if (!g) return 2'b11;
        if (b) return 2'b00;
        return ~s;
    endfunction

    // Reference update for one rising edge.
    task automatic model_edge();
        logic cyc;
        logic [1:0] mk;
        if (sleep) begin
            m_s1 = 0; m_s2 = 0; m_cnt = WAKE;
        end else if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_cnt = 0; m_dout = '0;
        end else begin
            cyc = acc_vld && !ce1_n && ce2 && !ce3_n && (m_cnt == 0);
            mk = cyc ? exp_mask(gw_n, bwe_n, bsel_n) : 2'b00;
            if (m_s1) m_dout = m_mem[m_s1_addr];
            m_s2 = m_s1;
            if (mk[0]) m_mem[addr][8:0] = wdata[8:0];
            if (mk[1]) m_mem[addr][17:9] = wdata[17:9];
            m_s1 = cyc && (mk == 2'b00);
            m_s1_addr = addr;
            if (m_cnt > 0) m_cnt--;
        end
    endtask

    task automatic check(input string tag);
        logic eo;
        eo = m_s2 && !oe_n && !sleep;
        total++;
        if (dq_oe !== eo) begin
            bad++;
            $display("FAIL %s dq_oe actual=%b expected=%b", tag, dq_oe, eo);
        end else if (eo) begin
            total++;
            if (rdata !== m_dout) begin
                bad++;
                $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, m_dout);
            end
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic drive(input logic c1, input logic c2, input logic c3, input logic v,
                         input logic g, input logic b, input logic [1:0] s,
                         input int a, input logic [17:0] d);
        ce1_n = c1; ce2 = c2; ce3_n = c3; acc_vld = v;
        gw_n = g; bwe_n = b; bsel_n = s; addr = AW'(a); wdata = d;
    endtask

    task automatic wr(input int a, input logic [17:0] d, input logic g, input logic b,
                      input logic [1:0] s, input string tag);
        drive(0, 1, 0, 1, g, b, s, a, d);
        step(tag);
    endtask

    task automatic rd(input int a, input string tag);
        drive(0, 1, 0, 1, 1, 1, 2'b11, a, 18'h0);
        step(tag);
    endtask

    task automatic idle(input string tag);
        drive(1, 0, 1, 0, 1, 1, 2'b11, 0, 18'h0);
        step(tag);
    endtask

    task automatic go_sleep(input logic v);
        sleep = v;
        if (v) begin m_s1 = 0; m_s2 = 0; m_cnt = WAKE; end
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        idle("R11"); idle("R11");
        rst_n = 1;
        check("R11");

        // Preload every word with a global write.
        for (int i = 0; i < DEPTH; i++) wr(i, 18'(i * 18'h0A53 + 18'h1111), 0, 1, 2'b11, "R2");

        // R2: global write ignores the byte controls.
        wr(3, 18'h2A5C3, 0, 0, 2'b10, "R2");
        rd(3, "R8");          // R8: read right after the write
        idle("R5");           // R5: data appears here
        idle("R6");           // R6: output stops

        // R4: one lane at a time, then both selects high is a read.
        wr(7, 18'h3FFFF, 0, 1, 2'b11, "R4");
        wr(7, 18'h00000, 1, 0, 2'b10, "R4");   // lane A only
        rd(7, "R4"); idle("R4"); idle("R4");
        wr(7, 18'h15555, 1, 0, 2'b01, "R4");   // lane B only
        wr(7, 18'h0AAAA, 1, 0, 2'b11, "R4");   // read, no write
        idle("R4"); rd(7, "R4"); idle("R4"); idle("R4");

        // R3: byte-write enable high makes it a read even with selects low.
        drive(0, 1, 0, 1, 1, 1, 2'b00, 9, 18'h12345); step("R3");
        idle("R3"); rd(9, "R3"); idle("R3"); idle("R3");

        // R1: each rejecting enable combination with a global write.
        drive(1, 1, 0, 1, 0, 1, 2'b11, 10, 18'h3C3C3); step("R1");
        drive(0, 0, 0, 1, 0, 1, 2'b11, 10, 18'h3C3C3); step("R1");
        drive(0, 1, 1, 1, 0, 1, 2'b11, 10, 18'h3C3C3); step("R1");
        drive(0, 1, 0, 0, 0, 1, 2'b11, 10, 18'h3C3C3); step("R1");
        rd(10, "R1"); idle("R1"); idle("R1");

        // R7: output enable acts without a clock edge.
        rd(12, "R7"); rd(13, "R7");
        oe_n = 1; #1 check("R7");
        oe_n = 0; #1 check("R7");
        idle("R6"); idle("R6");

        // R9 and R10: sleep drops a pending read, keeps data, then hold-off.
        rd(14, "R9");
        go_sleep(1); #1 check("R9");
        idle("R9"); idle("R9");
        @(negedge clk); go_sleep(0);
        for (int i = 0; i < WAKE; i++) wr(15, 18'h00001, 0, 1, 2'b11, "R10");
        wr(16, 18'h2BEEF, 0, 1, 2'b11, "R10");   // first accepted edge
        rd(15, "R10"); rd(16, "R10"); rd(14, "R9"); idle("R10"); idle("R10");

        // Random mix.
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (sleep) begin
                if (r < 40) go_sleep(0);
            end else if (r < 2) go_sleep(1);
            oe_n = ($urandom_range(0, 7) == 0);
            drive($urandom_range(0, 7) == 0, $urandom_range(0, 7) != 0,
                  $urandom_range(0, 7) == 0, $urandom_range(0, 5) != 0,
                  $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                  2'($urandom_range(0, 3)), $urandom_range(0, 7), 18'($urandom));
            step("R5");
        end
        go_sleep(0); oe_n = 0;
        for (int i = 0; i < WAKE + 2; i++) idle("R6");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule